// File: doc/BRIEF.md
# Bridge I/O Window Decoder

This block keeps the configuration state that describes one I/O address window of a bus bridge. It checks each incoming 32-bit I/O address against that window. Software programs the window one byte at a time through a small configuration port. Two 8-bit registers hold address bits 15:12 of the window bottom and top. Two 16-bit registers hold bits 31:16 of each.

The low nibble of each 8-bit register is a fixed code. It reports that the bridge decodes 32-bit I/O addresses. The window bottom is filled with zeros below bit 12 and the window top is filled with ones below bit 12, so the window always covers whole 4 KB pages. The claim output is combinational and says whether the current address lies in the window. A window whose bottom is above its top claims nothing.

Top module: `io_window_decoder`

## Requirements
- R1: After reset, offsets 1Ch and 1Dh read 01h, and offsets 30h, 31h, 32h and 33h read 00h. The window is then 0000_0000h to 0000_0FFFh, so address 0 is claimed and address 1000h is not.
- R2: Bits 3:0 of offsets 1Ch and 1Dh always read 0001b, whatever value was written to them.
- R3: Bits 7:4 of offset 1Ch are read/write and supply bottom address bits 15:12. Bits 7:4 of offset 1Dh are read/write and supply top address bits 15:12.
- R4: Each byte of the upper registers is written on its own. Offset 30h holds bottom bits 23:16, 31h holds bottom bits 31:24, 32h holds top bits 23:16, and 33h holds top bits 31:24. Each byte reads back as written.
- R5: The window bottom has address bits 11:0 equal to zero. The bottom address is claimed and the address one below it is not.
- R6: The window top has address bits 11:0 equal to FFFh. That address is claimed and the address one above it is not.
- R7: When the assembled 32-bit bottom is above the assembled 32-bit top, as unsigned numbers, no address is claimed.
- R8: The claim output follows the address input in the same cycle. A register write changes the decode only from the clock edge that accepts the write.
- R9: Reads from any offset other than 1Ch, 1Dh and 30h to 33h return 00h. Writes to those other offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgAddr | input | 8 | Configuration byte offset |
| cfgWrEn | input | 1 | Byte write strobe for cfgAddr |
| cfgWrData | input | 8 | Byte to write |
| cfgRdData | output | 8 | Byte read from cfgAddr, combinational |
| ioAddr | input | 32 | I/O address to decode |
| ioClaim | output | 1 | High when ioAddr lies inside the window |

## Verification
The bench uses the default parameters: offsets 1Ch, 1Dh, 30h and 32h, a capability code of 1, and a 32-bit address. With these values every upper byte lane can be written, and the bench probes window edges that differ only in bits 31:24. It also tests a bottom value of 1234_2000h against tops just above and just below it. That covers the 4 KB edges, the empty-window case, and the cycle in which a write takes effect.

// File: rtl/io_win_pkg.sv
package io_win_pkg;
  localparam int CFG_AW   = 8;
  localparam int CFG_DW   = 8;
  localparam int CAP_W    = 4;
  localparam int NIB_W    = CFG_DW - CAP_W;
  localparam int HALF_W   = 16;
  localparam int GRAN_W   = HALF_W - NIB_W;
  localparam int ADDR_W   = 32;
  localparam int UP_W     = ADDR_W - HALF_W;
  localparam int UP_BYTES = UP_W / CFG_DW;
  localparam int BIDX_W   = (UP_BYTES > 1) ? $clog2(UP_BYTES) : 1;

  // write strobes from control to datapath
  typedef struct packed {
    logic                baseNib;
    logic                limitNib;
    logic [UP_BYTES-1:0] baseUp;
    logic [UP_BYTES-1:0] limitUp;
  } winStb_t;

  // read select from control to datapath
  typedef struct packed {
    logic              selBase;
    logic              selLimit;
    logic              selUpBase;
    logic              selUpLimit;
    logic [BIDX_W-1:0] byteIdx;
  } winSel_t;
endpackage

// File: rtl/io_win_ctrl.sv
module io_win_ctrl
  import io_win_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE_OFF   = 8'h1C,
  parameter logic [CFG_AW-1:0] LIMIT_OFF  = 8'h1D,
  parameter logic [CFG_AW-1:0] UBASE_OFF  = 8'h30,
  parameter logic [CFG_AW-1:0] ULIMIT_OFF = 8'h32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  output winStb_t           stb,
  output winSel_t           sel
);
  logic [CFG_AW-1:0] ubDiff;
  logic [CFG_AW-1:0] ulDiff;

  always_comb begin
    ubDiff = cfgAddr - UBASE_OFF;
    ulDiff = cfgAddr - ULIMIT_OFF;
    sel = '0;
    sel.selBase  = (cfgAddr == BASE_OFF);
    sel.selLimit = (cfgAddr == LIMIT_OFF);
    if (cfgAddr >= UBASE_OFF && ubDiff < CFG_AW'(UP_BYTES)) begin
      sel.selUpBase = 1'b1;
      sel.byteIdx   = ubDiff[BIDX_W-1:0];
    end else if (cfgAddr >= ULIMIT_OFF && ulDiff < CFG_AW'(UP_BYTES)) begin
      sel.selUpLimit = 1'b1;
      sel.byteIdx    = ulDiff[BIDX_W-1:0];
    end
  end

  always_comb begin
    stb = '0;
    stb.baseNib  = cfgWrEn && sel.selBase;
    stb.limitNib = cfgWrEn && sel.selLimit;
    for (int i = 0; i < UP_BYTES; i++) begin
      stb.baseUp[i]  = cfgWrEn && sel.selUpBase  && (sel.byteIdx == BIDX_W'(i));
      stb.limitUp[i] = cfgWrEn && sel.selUpLimit && (sel.byteIdx == BIDX_W'(i));
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb)); // R9

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |-> (stb == '0)); // R9
endmodule

// File: rtl/io_win_dp.sv
module io_win_dp
  import io_win_pkg::*;
#(
  parameter logic [CAP_W-1:0] CAP_CODE = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStb_t           stb,
  input  winSel_t           sel,
  input  logic [CFG_DW-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] ioAddr,
  output logic [CFG_DW-1:0] cfgRdData,
  output logic              ioClaim
);
  logic [NIB_W-1:0]               baseNib;
  logic [NIB_W-1:0]               limitNib;
  logic [UP_BYTES-1:0][CFG_DW-1:0] upBase;
  logic [UP_BYTES-1:0][CFG_DW-1:0] upLimit;
  logic [ADDR_W-1:0]              baseFull;
  logic [ADDR_W-1:0]              limitFull;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseNib  <= '0;
      limitNib <= '0;
    end else begin
      if (stb.baseNib)  baseNib  <= cfgWrData[CFG_DW-1:CAP_W];
      if (stb.limitNib) limitNib <= cfgWrData[CFG_DW-1:CAP_W];
    end
  end

  for (genvar b = 0; b < UP_BYTES; b++) begin : g_up
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        upBase[b]  <= '0;
        upLimit[b] <= '0;
      end else begin
        if (stb.baseUp[b])  upBase[b]  <= cfgWrData;
        if (stb.limitUp[b]) upLimit[b] <= cfgWrData;
      end
    end
  end

  // window assembly: 4 KB pages, bottom zero-filled, top one-filled
  assign baseFull  = {upBase,  baseNib,  {GRAN_W{1'b0}}};
  assign limitFull = {upLimit, limitNib, {GRAN_W{1'b1}}};

  // an inverted window fails one of the two bounds on its own
  assign ioClaim = (ioAddr >= baseFull) && (ioAddr <= limitFull);

  always_comb begin
    cfgRdData = '0;
    if (sel.selBase)         cfgRdData = {baseNib, CAP_CODE};
    else if (sel.selLimit)   cfgRdData = {limitNib, CAP_CODE};
    else if (sel.selUpBase)  cfgRdData = upBase[sel.byteIdx];
    else if (sel.selUpLimit) cfgRdData = upLimit[sel.byteIdx];
  end

  AST_NIB_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    stb.baseNib |=> (baseNib == $past(cfgWrData[CFG_DW-1:CAP_W]))); // R3

  AST_NIB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.limitNib |=> $stable(limitNib)); // R9

  AST_CAP_READ: assert property (@(posedge clk) disable iff (!rstN)
    (sel.selBase || sel.selLimit) |-> (cfgRdData[CAP_W-1:0] == CAP_CODE)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !(sel.selBase || sel.selLimit || sel.selUpBase || sel.selUpLimit)
      |-> (cfgRdData == '0)); // R9

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (baseFull > limitFull) |-> !ioClaim); // R7

  AST_CLAIM_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(ioAddr) && ($past(stb) == '0)) |-> $stable(ioClaim)); // R8
endmodule

// File: rtl/io_window_decoder.sv
module io_window_decoder
  import io_win_pkg::*;
#(
  parameter logic [CFG_AW-1:0] BASE_OFF   = 8'h1C,
  parameter logic [CFG_AW-1:0] LIMIT_OFF  = 8'h1D,
  parameter logic [CFG_AW-1:0] UBASE_OFF  = 8'h30,
  parameter logic [CFG_AW-1:0] ULIMIT_OFF = 8'h32,
  parameter logic [CAP_W-1:0]  CAP_CODE   = 4'h1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_AW-1:0] cfgAddr,
  input  logic              cfgWrEn,
  input  logic [CFG_DW-1:0] cfgWrData,
  output logic [CFG_DW-1:0] cfgRdData,
  input  logic [ADDR_W-1:0] ioAddr,
  output logic              ioClaim
);
  winStb_t stb;
  winSel_t sel;

  io_win_ctrl #(
    .BASE_OFF(BASE_OFF), .LIMIT_OFF(LIMIT_OFF),
    .UBASE_OFF(UBASE_OFF), .ULIMIT_OFF(ULIMIT_OFF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .stb(stb), .sel(sel)
  );

  io_win_dp #(.CAP_CODE(CAP_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sel(sel), .cfgWrData(cfgWrData),
    .ioAddr(ioAddr), .cfgRdData(cfgRdData), .ioClaim(ioClaim)
  );
endmodule

// File: tb/io_window_decoder_test.sv
module io_window_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  cfgAddr = '0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic [7:0]  cfgRdData;
  logic [31:0] ioAddr = '0;
  logic        ioClaim;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    bit         chkRd;
    bit         chkClaim;
    logic [7:0] rd;
    logic       cl;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  io_window_decoder uut (
    .clk(clk), .rstN(rstN), .cfgAddr(cfgAddr), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .ioAddr(ioAddr), .ioClaim(ioClaim)
  );

  // driver: one cycle of stimulus; the expectation is checked before the next edge
  task automatic cyc(input logic [7:0] a, input logic we, input logic [7:0] d,
                     input logic [31:0] io, input bit cr, input logic [7:0] er,
                     input bit cc, input logic ec, input string tag);
    exp_t e;
    @(posedge clk); #1;
    cfgAddr = a; cfgWrEn = we; cfgWrData = d; ioAddr = io;
    if (cr || cc) begin
      e.chkRd = cr; e.rd = er; e.chkClaim = cc; e.cl = ec; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(a, 1'b1, d, 32'h0, 0, 8'h0, 0, 1'b0, "");
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    cyc(a, 1'b0, 8'h0, 32'h0, 1, exp, 0, 1'b0, tag);
  endtask

  task automatic cl(input logic [31:0] io, input logic exp, input string tag);
    cyc(8'h00, 1'b0, 8'h0, io, 0, 8'h0, 1, exp, tag);
  endtask

  // monitor: compares at the falling edge, four ns after the driver
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        if (e.chkRd) begin
          checks++;
          if (cfgRdData !== e.rd) begin
            fails++;
            $display("FAIL %s: cfgRdData actual %h expected %h", e.tag, cfgRdData, e.rd);
          end
        end
        if (e.chkClaim) begin
          checks++;
          if (ioClaim !== e.cl) begin
            fails++;
            $display("FAIL %s: ioClaim actual %b expected %b", e.tag, ioClaim, e.cl);
          end
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset values and reset window
    rd(8'h1C, 8'h01, "R1 base byte reset");
    rd(8'h1D, 8'h01, "R1 limit byte reset");
    rd(8'h30, 8'h00, "R1 upper base lo reset");
    rd(8'h31, 8'h00, "R1 upper base hi reset");
    rd(8'h32, 8'h00, "R1 upper limit lo reset");
    rd(8'h33, 8'h00, "R1 upper limit hi reset");
    cl(32'h0000_0000, 1'b1, "R1 reset window bottom");
    cl(32'h0000_1000, 1'b0, "R1 reset window above");
    // R2 / R3 fixed nibble and writable nibble
    wr(8'h1C, 8'hFF);
    rd(8'h1C, 8'hF1, "R2 R3 base byte after FFh");
    wr(8'h1D, 8'h3A);
    rd(8'h1D, 8'h31, "R2 R3 limit byte after 3Ah");
    // program window 1234_2000h .. 1234_5FFFh
    wr(8'h1C, 8'h20);
    wr(8'h1D, 8'h50);
    wr(8'h30, 8'h34);
    wr(8'h31, 8'h12);
    wr(8'h32, 8'h34);
    wr(8'h33, 8'h12);
    rd(8'h31, 8'h12, "R4 upper base hi byte");
    rd(8'h32, 8'h34, "R4 upper limit lo byte");
    rd(8'h30, 8'h34, "R4 upper base lo byte");
    cl(32'h1234_1FFF, 1'b0, "R5 one below bottom");
    cl(32'h1234_2000, 1'b1, "R5 bottom");
    cl(32'h1234_5FFF, 1'b1, "R6 top");
    cl(32'h1234_6000, 1'b0, "R6 one above top");
    cl(32'h1234_3ABC, 1'b1, "R3 inside window");
    cl(32'h1334_3000, 1'b0, "R4 bits 31:24 differ");
    // R9 unmapped offsets
    rd(8'h20, 8'h00, "R9 unmapped read 20h");
    wr(8'h1E, 8'hFF);
    wr(8'h34, 8'hFF);
    rd(8'h1C, 8'h21, "R9 base byte after stray writes");
    rd(8'h34, 8'h00, "R9 unmapped read 34h");
    rd(8'h33, 8'h12, "R9 upper limit hi after stray writes");
    cl(32'h1234_5000, 1'b1, "R9 window intact");
    // R8 write takes effect after the edge; R7 inverted window
    cyc(8'h1D, 1'b1, 8'h10, 32'h1234_3000, 0, 8'h0, 1, 1'b1, "R8 old decode during write");
    cl(32'h1234_3000, 1'b0, "R8 R7 decode after write");
    cl(32'h1234_2000, 1'b0, "R7 inverted window bottom");
    cl(32'h1234_1000, 1'b0, "R7 inverted window top page");
    wr(8'h33, 8'h13);
    cl(32'h1234_3000, 1'b1, "R4 limit raised by byte 33h");
    cl(32'h1334_1FFF, 1'b1, "R6 new top");
    cl(32'h1334_2000, 1'b0, "R6 above new top");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule